// File: doc/BRIEF.md
# Line Scroll Controller

This block steers the horizontal scrolling of a single character row on a character display. The host issues a scroll command with a direction and a speed. It then selects the row to move with a row-select write. After that, the block advances a pixel-granular offset on frame ticks, once every `speed` ticks. The outputs are the leftmost character column, the pixel shift inside that character, and the row that is moving. The renderer uses them to shift the row; the renderer and the display memory are outside this block.

The virtual line is `COLS` characters wide (22 by default). The last two character positions are off-screen storage. One character is `CHAR_PIX` pixels (6: five font columns plus one space). The offset wraps around the virtual line in both directions. After each whole-character move the block raises a completion pulse to the host, held for `PULSE_CYC` clocks. The pulse length is set to fit the host's timing window.

Once a row has been scrolled, it stays locked. A later restart must name the same row, and a restart that names any other row is refused. Only a scroll reset releases the lock.

Top module: `line_scroll_ctrl`

## Requirements
- R1: After reset, `lead_col` = 0, `pix_shift` = 0, `row_sel` = 0, `scrolling` = 0 and `step_done` = 0.
- R2: A command write (`cmd_is_row` = 0) carries the direction in data bits 7:6, where 2'b01 means right and 2'b10 means left. Either value stops motion and arms the block. A following row write (`cmd_is_row` = 1, row in data bits 2:0) then starts scrolling. `scrolling` and `row_sel` change on the edge that samples that row write.
- R3: The command data bits 5:0 give the number of frame ticks per one-pixel step. The offset moves on every `speed`-th tick, on the edge that samples that tick.
- R4: With a speed of 0 the block accepts the row and shows `scrolling` = 1, but the offset never moves.
- R5: In the left direction each step adds one pixel. The shift runs 0..5, then returns to 0 and `lead_col` increments. Column 21 wraps to column 0.
- R6: In the right direction each step subtracts one pixel. Shift 0 goes to shift 5 of the previous column. Column 0, shift 0 wraps to column 21, shift 5.
- R7: When a step lands on shift 0, `step_done` is high for exactly `PULSE_CYC` clocks, starting at the edge of that step.
- R8: Direction code 2'b11 stops motion and keeps the current offset.
- R9: Direction code 2'b00 returns the offset to column 0, shift 0, stops motion and releases the row lock.
- R10: Once a row has been accepted, a later row write that names a different row is refused and `scrolling` stays 0. The same row is accepted again.
- R11: A row write that does not follow a direction command 2'b01 or 2'b10 is ignored: `row_sel` and `scrolling` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host write strobe, one clock |
| cmd_is_row | input | 1 | 0 = scroll command write, 1 = row-select write |
| cmd_data | input | SPEED_W+2 | Write data (direction 7:6, speed 5:0, or row in the low bits) |
| frame_tick | input | 1 | One-clock pulse per display frame |
| lead_col | output | COL_W | Leftmost displayed character column |
| pix_shift | output | SH_W | Pixel shift within the leading character |
| row_sel | output | ROW_W | Row being scrolled |
| scrolling | output | 1 | Motion enabled |
| step_done | output | 1 | Whole-character completion pulse to host |

## Verification
Every registered result changes on the clock edge that samples its cause. This holds for a command write, a row write, and the frame tick that completes a speed count. `step_done` rises on that same edge and stays high for `PULSE_CYC` clocks. The bench drives inputs and samples outputs on the falling edge. It therefore compares the outputs with its reference model half a cycle after each edge the model has already applied. Directed checks are made once a task returns to a falling edge, after every edge that task caused has passed.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    DIR_ZERO  = 2'b00,
    DIR_RIGHT = 2'b01,
    DIR_LEFT  = 2'b10,
    DIR_HOLD  = 2'b11
  } scroll_dir_e;
endpackage

// File: rtl/lsc_cmd.sv
module lsc_cmd import lsc_pkg::*; #(
  parameter int SPEED_W = 6,
  parameter int ROW_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic               cmd_is_row,
  input  logic [SPEED_W+1:0] cmd_data,
  output logic               running,
  output logic               armed,
  output logic               dir_left,
  output logic [SPEED_W-1:0] speed,
  output logic [ROW_W-1:0]   row,
  output logic               zero_req
);
  scroll_dir_e dir_in;
  logic        locked;
  logic        row_ok;

  assign dir_in   = scroll_dir_e'(cmd_data[SPEED_W+1:SPEED_W]);
  assign zero_req = cmd_wr && !cmd_is_row && (dir_in == DIR_ZERO);
  assign row_ok   = !locked || (row == cmd_data[ROW_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      armed    <= 1'b0;
      locked   <= 1'b0;
      dir_left <= 1'b0;
      speed    <= '0;
      row      <= '0;
    end else if (cmd_wr && !cmd_is_row) begin
      running <= 1'b0;
      speed   <= cmd_data[SPEED_W-1:0];
      case (dir_in)
        DIR_ZERO: begin
          armed  <= 1'b0;
          locked <= 1'b0;
        end
        DIR_RIGHT, DIR_LEFT: begin
          armed    <= 1'b1;
          dir_left <= (dir_in == DIR_LEFT);
        end
        default: armed <= 1'b0;
      endcase
    end else if (cmd_wr && cmd_is_row && armed) begin
      armed <= 1'b0;
      if (row_ok) begin
        row     <= cmd_data[ROW_W-1:0];
        locked  <= 1'b1;
        running <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsc_pacer.sv
module lsc_pacer #(
  parameter int SPEED_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               running,
  input  logic               frame_tick,
  input  logic [SPEED_W-1:0] speed,
  output logic               step_evt
);
  logic [SPEED_W-1:0] cnt;

  function automatic logic count_hit(input logic [SPEED_W-1:0] c,
                                     input logic [SPEED_W-1:0] s);
    return (s != '0) && (({1'b0, c} + 1'b1) == {1'b0, s});
  endfunction

  assign step_evt = running && frame_tick && count_hit(cnt, speed);

  always_ff @(posedge clk) begin
    if (!rst_n || !running) cnt <= '0;
    else if (frame_tick)     cnt <= step_evt ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/lsc_offset.sv
module lsc_offset #(
  parameter int COLS     = 22,
  parameter int CHAR_PIX = 6,
  localparam int COL_W   = $clog2(COLS),
  localparam int SH_W    = $clog2(CHAR_PIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_evt,
  input  logic             dir_left,
  input  logic             zero_req,
  output logic [COL_W-1:0] col,
  output logic [SH_W-1:0]  shift,
  output logic             char_evt
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [SH_W-1:0]  SH_LAST  = SH_W'(CHAR_PIX - 1);

  function automatic logic [COL_W+SH_W-1:0] move_left(input logic [COL_W-1:0] c,
                                                      input logic [SH_W-1:0] s);
    if (s == SH_LAST) return {((c == COL_LAST) ? '0 : c + 1'b1), {SH_W{1'b0}}};
    return {c, s + 1'b1};
  endfunction

  function automatic logic [COL_W+SH_W-1:0] move_right(input logic [COL_W-1:0] c,
                                                       input logic [SH_W-1:0] s);
    if (s == '0) return {((c == '0) ? COL_LAST : c - 1'b1), SH_LAST};
    return {c, s - 1'b1};
  endfunction

  logic [COL_W+SH_W-1:0] nxt;
  assign nxt      = dir_left ? move_left(col, shift) : move_right(col, shift);
  assign char_evt = step_evt && !zero_req && (nxt[SH_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || zero_req) begin
      col   <= '0;
      shift <= '0;
    end else if (step_evt) begin
      {col, shift} <= nxt;
    end
  end
endmodule

// File: rtl/lsc_pulse.sv
module lsc_pulse #(
  parameter int PULSE_CYC = 4,
  localparam int PC_W     = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic [PC_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)         left <= '0;
    else if (fire)      left <= PC_W'(PULSE_CYC);
    else if (left != 0) left <= left - 1'b1;
  end

  assign pulse = (left != '0);
endmodule

// File: rtl/line_scroll_ctrl.sv
module line_scroll_ctrl #(
  parameter int COLS      = 22,
  parameter int CHAR_PIX  = 6,
  parameter int ROWS      = 8,
  parameter int SPEED_W   = 6,
  parameter int PULSE_CYC = 4,
  localparam int COL_W    = $clog2(COLS),
  localparam int SH_W     = $clog2(CHAR_PIX),
  localparam int ROW_W    = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic               cmd_is_row,
  input  logic [SPEED_W+1:0] cmd_data,
  input  logic               frame_tick,
  output logic [COL_W-1:0]   lead_col,
  output logic [SH_W-1:0]    pix_shift,
  output logic [ROW_W-1:0]   row_sel,
  output logic               scrolling,
  output logic               step_done
);
  logic               running, armed, dir_left, zero_req;
  logic               step_evt, char_evt;
  logic [SPEED_W-1:0] spd;

  lsc_cmd #(.SPEED_W(SPEED_W), .ROW_W(ROW_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_is_row(cmd_is_row),
    .cmd_data(cmd_data), .running(running), .armed(armed),
    .dir_left(dir_left), .speed(spd), .row(row_sel), .zero_req(zero_req)
  );

  lsc_pacer #(.SPEED_W(SPEED_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .running(running), .frame_tick(frame_tick),
    .speed(spd), .step_evt(step_evt)
  );

  lsc_offset #(.COLS(COLS), .CHAR_PIX(CHAR_PIX)) u_offset (
    .clk(clk), .rst_n(rst_n), .step_evt(step_evt), .dir_left(dir_left),
    .zero_req(zero_req), .col(lead_col), .shift(pix_shift), .char_evt(char_evt)
  );

  lsc_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(char_evt), .pulse(step_done)
  );

  assign scrolling = running;
endmodule

// File: rtl/line_scroll_ctrl_chk.sv
module line_scroll_ctrl_chk #(
  parameter int COLS = 22, parameter int CHAR_PIX = 6,
  parameter int COL_W = 5, parameter int SH_W = 3, parameter int ROW_W = 3,
  parameter int SPEED_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_wr,
  input logic               cmd_is_row,
  input logic [SPEED_W+1:0] cmd_data,
  input logic [COL_W-1:0]   lead_col,
  input logic [SH_W-1:0]    pix_shift,
  input logic [ROW_W-1:0]   row_sel,
  input logic               scrolling,
  input logic               step_done,
  input logic               step_evt,
  input logic               zero_req,
  input logic               armed,
  input logic [SPEED_W-1:0] spd
);
  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pix_shift) < CHAR_PIX) && (int'(lead_col) < COLS));

  assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!scrolling && !cmd_wr) |=> ($stable(lead_col) && $stable(pix_shift)));

  assert_zero_speed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spd == '0 && !cmd_wr) |=> ($stable(lead_col) && $stable(pix_shift)));

  assert_step_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !zero_req) |=> !$stable(pix_shift));

  assert_pulse_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_done) |-> (pix_shift == '0));

  assert_reset_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_is_row && cmd_data[SPEED_W+1:SPEED_W] == 2'b00)
      |=> (lead_col == '0 && pix_shift == '0 && !scrolling));

  assert_unarmed_row_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_is_row && !armed) |=> ($stable(row_sel) && $stable(scrolling)));
endmodule

bind line_scroll_ctrl line_scroll_ctrl_chk #(
  .COLS(COLS), .CHAR_PIX(CHAR_PIX), .COL_W(COL_W), .SH_W(SH_W),
  .ROW_W(ROW_W), .SPEED_W(SPEED_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_is_row(cmd_is_row),
  .cmd_data(cmd_data), .lead_col(lead_col), .pix_shift(pix_shift),
  .row_sel(row_sel), .scrolling(scrolling), .step_done(step_done),
  .step_evt(step_evt), .zero_req(zero_req), .armed(armed), .spd(spd)
);

// File: tb/line_scroll_ctrl_test.sv
module line_scroll_ctrl_test;
  localparam int PULSE = 4;
  localparam int VPIX  = 22 * 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0, cmd_is_row = 1'b0, frame_tick = 1'b0;
  logic [7:0] cmd_data = '0;
  logic [4:0] lead_col;
  logic [2:0] pix_shift, row_sel;
  logic       scrolling, step_done;

  int tests = 0, fails = 0;
  bit done = 0;

  line_scroll_ctrl #(.PULSE_CYC(PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_is_row(cmd_is_row),
    .cmd_data(cmd_data), .frame_tick(frame_tick), .lead_col(lead_col),
    .pix_shift(pix_shift), .row_sel(row_sel), .scrolling(scrolling),
    .step_done(step_done)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  int m_pix, m_speed, m_cnt, m_row, m_pulse;
  bit m_run, m_armed, m_locked, m_left;
  int rises = 0;
  bit prev_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pix = 0; m_speed = 0; m_cnt = 0; m_row = 0; m_pulse = 0;
      m_run = 0; m_armed = 0; m_locked = 0; m_left = 0;
    end else begin
      bit landed;
      bit zero;
      landed = 0;
      zero = cmd_wr && !cmd_is_row && cmd_data[7:6] == 2'b00;
      if (m_run && frame_tick && m_speed != 0) begin
        m_cnt++;
        if (m_cnt == m_speed) begin
          m_cnt = 0;
          if (!zero) begin
            m_pix = m_left ? (m_pix + 1) % VPIX : (m_pix + VPIX - 1) % VPIX;
            landed = (m_pix % 6 == 0);
          end
        end
      end
      if (landed) m_pulse = PULSE;
      else if (m_pulse > 0) m_pulse--;
      if (cmd_wr && !cmd_is_row) begin
        m_run = 0; m_cnt = 0; m_speed = cmd_data[5:0];
        case (cmd_data[7:6])
          2'b00: begin m_pix = 0; m_armed = 0; m_locked = 0; end
          2'b01: begin m_armed = 1; m_left = 0; end
          2'b10: begin m_armed = 1; m_left = 1; end
          default: m_armed = 0;
        endcase
      end else if (cmd_wr && cmd_is_row && m_armed) begin
        m_armed = 0;
        if (!m_locked || m_row == cmd_data[2:0]) begin
          m_row = cmd_data[2:0]; m_locked = 1; m_run = 1; m_cnt = 0;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 lead_col model", lead_col, m_pix / 6);
      check("R5 pix_shift model", pix_shift, m_pix % 6);
      check("R2 row_sel model", row_sel, m_row);
      check("R2 scrolling model", scrolling, m_run);
      check("R7 step_done model", step_done, m_pulse > 0);
      if (step_done && !prev_done) rises++;
      prev_done = step_done;
    end
  end

  task automatic wr(input bit is_row, input logic [7:0] d);
    @(negedge clk); cmd_wr = 1; cmd_is_row = is_row; cmd_data = d;
    @(negedge clk); cmd_wr = 0; cmd_is_row = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_tick = 1;
      @(negedge clk); frame_tick = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 col", lead_col, 0);
    check("R1 shift", pix_shift, 0);
    check("R1 row", row_sel, 0);
    check("R1 scrolling", scrolling, 0);
    check("R1 done", step_done, 0);

    wr(1, 8'd5);
    check("R11 row ignored", row_sel, 0);
    check("R11 not scrolling", scrolling, 0);

    wr(0, 8'b10_000010);
    check("R2 armed only", scrolling, 0);
    wr(1, 8'd3);
    check("R2 scrolling", scrolling, 1);
    check("R2 row", row_sel, 3);
    ticks(1);
    check("R3 first tick no move", pix_shift, 0);
    ticks(1);
    check("R3 second tick moves", pix_shift, 1);
    ticks(12);
    check("R5 col after 7 px", lead_col, 1);
    check("R5 shift after 7 px", pix_shift, 1);

    wr(0, 8'b10_000001);
    wr(1, 8'd3);
    rises = 0;
    ticks(122);
    check("R5 col 21", lead_col, 21);
    check("R5 shift 3", pix_shift, 3);
    ticks(3);
    check("R5 wrap col", lead_col, 0);
    check("R5 wrap shift", pix_shift, 0);
    repeat (PULSE + 1) @(negedge clk);
    check("R7 pulse count", rises, 21);

    wr(0, 8'b11_000001);
    ticks(5);
    check("R8 stopped", scrolling, 0);
    check("R8 held shift", pix_shift, 0);

    wr(0, 8'b10_000001);
    wr(1, 8'd4);
    check("R10 refused", scrolling, 0);
    check("R10 row kept", row_sel, 3);
    ticks(3);
    check("R10 no motion", pix_shift, 0);
    wr(0, 8'b10_000001);
    wr(1, 8'd3);
    check("R10 accepted", scrolling, 1);

    wr(0, 8'b01_000001);
    wr(1, 8'd3);
    ticks(1);
    check("R6 wrap col", lead_col, 21);
    check("R6 wrap shift", pix_shift, 5);
    ticks(2);
    check("R6 shift down", pix_shift, 3);

    wr(0, 8'b01_000000);
    wr(1, 8'd3);
    check("R4 accepted", scrolling, 1);
    ticks(4);
    check("R4 frozen shift", pix_shift, 3);
    check("R4 frozen col", lead_col, 21);

    wr(0, 8'b00_000011);
    check("R9 col", lead_col, 0);
    check("R9 shift", pix_shift, 0);
    check("R9 stopped", scrolling, 0);
    wr(0, 8'b10_000001);
    wr(1, 8'd6);
    check("R9 lock released", row_sel, 6);
    check("R9 running", scrolling, 1);
    ticks(6);
    check("R9 one char", lead_col, 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule